// File: doc/BRIEF.md
# Single-to-Dual Pixel Stream Splitter

This block sits on the input side of a two-lane display link. It receives one pixel per clock, qualified by a data-enable level and carried with horizontal and vertical sync. It produces a two-lane output word made of a lane-A pixel and a lane-B pixel. A mode input selects one of three behaviours:

- Pass a single pixel through on lane A with lane B held off.
- Forward an input that already carries two pixels.
- Fold the single-pixel stream into odd/even pairs.

In the folding mode the pair phase is set again at every start of an active region. Misaligned region lengths are reported on sticky error flags.

The stream rules are simple. The input data enable is the valid qualifier. `in_ready` is the only back-pressure signal, and it drops only while the block is powered down; any pixel presented then is discarded. The output side has no ready: a video link cannot stall, so `out_valid` is a strobe that the consumer must take on the cycle it appears.

A strobe-edge select puts either one or two register stages in front of the pairing logic. This keeps everything in one clock domain. Power-down turns the output-enable flag off, zeroes every output and clears the pair phase, so that normal operation resumes cleanly after release.

Top module: `pix_pair_split`

## Requirements
- R1: While the synchronous reset `rst` is high, every output register, the pair phase and both error flags are zero. This includes `out_oe`.
- R2: Mode code 2'b10 is split mode. In split mode, the first pixel with `in_de` high after a low cycle is the odd pixel and appears on lane A. The next pixel with `in_de` high is the even pixel and appears on lane B. With `edge_sel` low, the pair appears with `out_valid` high for one cycle, two clock edges after the even pixel is presented. `out_valid` is never high on two consecutive cycles in split mode, and both pixel outputs are zero on cycles where `out_valid` is low.
- R3: `out_de`, `out_hs` and `out_vs` repeat the input controls with the same latency as the pixel data. On a split-mode pair cycle they are the controls of the even pixel.
- R4: In split mode, if `in_de` falls while an odd pixel has no partner, the odd pixel is emitted alone on lane A with lane B zero and `out_valid` high. On that cycle `err_odd_len` rises and stays high until reset.
- R5: In split mode, an odd number of `in_de`-low cycles between two active regions sets the sticky flag `err_blank_par` on the output cycle of the new region's first pixel. An even run leaves the flag low, and the blanking before the first region after reset is not judged. The new region still starts with its first pixel on lane A.
- R6: Mode codes 2'b00 and 2'b11 are single mode. In single mode, each pixel with `in_de` high appears on lane A with `out_valid` high, two edges after it is presented. `out_pix_b` stays zero and `out_b_en` stays low whatever `in_pix_b` carries.
- R7: Mode code 2'b01 is dual mode. In dual mode, `in_pix_a` and `in_pix_b` of each enabled cycle appear together on lanes A and B with `out_valid` high, and `out_b_en` is high.
- R8: While `pwr_down` is high, `in_ready` is low. From the next edge on, `out_oe` is low and all other outputs except the error flags are zero. The pair phase is cleared without a flush, and after release pairing restarts fresh at the next enabled pixel.
- R9: With `edge_sel` high, every output appears one clock later than with `edge_sel` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00/11 single, 01 dual, 10 split |
| pwr_down | input | 1 | Power-down, active high |
| edge_sel | input | 1 | Capture-phase select: 1 adds a capture stage |
| in_de | input | 1 | Input data enable (stream valid) |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_pix_a | input | PIX_W | Input pixel (first pixel in dual mode) |
| in_pix_b | input | PIX_W | Second input pixel, used in dual mode only |
| in_ready | output | 1 | Input accepted; low only in power-down |
| out_oe | output | 1 | Output driver enable; low in power-down and reset |
| out_valid | output | 1 | Output word strobe |
| out_b_en | output | 1 | Lane-B enable |
| out_pix_a | output | PIX_W | Lane-A pixel |
| out_pix_b | output | PIX_W | Lane-B pixel |
| out_de | output | 1 | Delayed data enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| err_odd_len | output | 1 | Sticky: active region of odd length |
| err_blank_par | output | 1 | Sticky: blanking run of odd length |

## Verification
A stuck or inverted pair phase shows up on the first pair of the next region. The even pixel lands on lane A, or `out_valid` fires on the odd pixel. This is visible two edges after the second enabled pixel.

A phase that is not cleared on a falling data enable, on power-down or on a mode change shows up as a stale pixel. Either a spurious flush appears one edge after the cause, or an old pixel turns up on lane A of the first pair after it. A wrong blanking parity count is seen on `err_blank_par` on the output cycle of the new region's first pixel. A wrong capture-stage choice shifts every output by one cycle.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_DUAL   = 2'b01,
    MODE_SPLIT  = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;
endpackage

// File: rtl/pps_feed.sv
module pps_feed #(
  parameter int PIX_W    = 24,
  parameter int LATE_STG = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             sel_late,
  input  logic             de,
  input  logic             hs,
  input  logic             vs,
  input  logic [PIX_W-1:0] pa,
  input  logic [PIX_W-1:0] pb,
  output logic             f_de,
  output logic             f_hs,
  output logic             f_vs,
  output logic [PIX_W-1:0] f_pa,
  output logic [PIX_W-1:0] f_pb
);
  localparam int FW    = 3 + 2 * PIX_W;
  localparam int DEPTH = 1 + LATE_STG;

  logic [DEPTH-1:0][FW-1:0] stg;
  logic [FW-1:0]            pick;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      stg <= '0;
    end else begin
      stg[0] <= {de, hs, vs, pa, pb};
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign pick = sel_late ? stg[DEPTH-1] : stg[0];
  assign {f_de, f_hs, f_vs, f_pa, f_pb} = pick;
endmodule

// File: rtl/pps_pair.sv
module pps_pair #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             f_de,
  input  logic [PIX_W-1:0] f_pa,
  output logic             p_valid,
  output logic [PIX_W-1:0] p_a,
  output logic [PIX_W-1:0] p_b,
  output logic             flush
);
  logic             have_odd;
  logic [PIX_W-1:0] odd_q;

  always_comb begin
    p_valid = have_odd;
    p_a     = odd_q;
    p_b     = f_de ? f_pa : '0;
    flush   = have_odd && !f_de;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      have_odd <= 1'b0;
      odd_q    <= '0;
    end else if (have_odd) begin
      have_odd <= 1'b0;
    end else if (f_de) begin
      have_odd <= 1'b1;
      odd_q    <= f_pa;
    end
  end
endmodule

// File: rtl/pps_blank.sv
module pps_blank (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic f_de,
  output logic err_set
);
  logic prev_de;
  logic seen;
  logic par;

  assign err_set = f_de && !prev_de && seen && par;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev_de <= 1'b0;
      seen    <= 1'b0;
      par     <= 1'b0;
    end else begin
      prev_de <= f_de;
      if (f_de) begin
        seen <= 1'b1;
        par  <= 1'b0;
      end else begin
        par <= ~par;
      end
    end
  end
endmodule

// File: rtl/pix_pair_split.sv
module pix_pair_split
  import pps_pkg::*;
#(
  parameter int CH_W     = 8,
  parameter int N_CH     = 3,
  parameter int LATE_STG = 1,
  parameter int PIX_W    = CH_W * N_CH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             pwr_down,
  input  logic             edge_sel,
  input  logic             in_de,
  input  logic             in_hs,
  input  logic             in_vs,
  input  logic [PIX_W-1:0] in_pix_a,
  input  logic [PIX_W-1:0] in_pix_b,
  output logic             in_ready,
  output logic             out_oe,
  output logic             out_valid,
  output logic             out_b_en,
  output logic [PIX_W-1:0] out_pix_a,
  output logic [PIX_W-1:0] out_pix_b,
  output logic             out_de,
  output logic             out_hs,
  output logic             out_vs,
  output logic             err_odd_len,
  output logic             err_blank_par
);
  logic             f_de, f_hs, f_vs;
  logic [PIX_W-1:0] f_pa, f_pb;
  logic             p_valid, flush, blank_set;
  logic [PIX_W-1:0] p_a, p_b;
  logic             is_split;
  logic             split_clr;

  assign in_ready  = !pwr_down;
  assign is_split  = (mode == MODE_SPLIT);
  assign split_clr = pwr_down || !is_split;

  pps_feed #(.PIX_W(PIX_W), .LATE_STG(LATE_STG)) i_feed (
    .clk(clk), .rst(rst), .clr(pwr_down), .sel_late(edge_sel),
    .de(in_de), .hs(in_hs), .vs(in_vs), .pa(in_pix_a), .pb(in_pix_b),
    .f_de(f_de), .f_hs(f_hs), .f_vs(f_vs), .f_pa(f_pa), .f_pb(f_pb)
  );

  pps_pair #(.PIX_W(PIX_W)) i_pair (
    .clk(clk), .rst(rst), .clr(split_clr), .f_de(f_de), .f_pa(f_pa),
    .p_valid(p_valid), .p_a(p_a), .p_b(p_b), .flush(flush)
  );

  pps_blank i_blank (
    .clk(clk), .rst(rst), .clr(split_clr), .f_de(f_de), .err_set(blank_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_oe        <= 1'b0;
      out_valid     <= 1'b0;
      out_b_en      <= 1'b0;
      out_pix_a     <= '0;
      out_pix_b     <= '0;
      out_de        <= 1'b0;
      out_hs        <= 1'b0;
      out_vs        <= 1'b0;
      err_odd_len   <= 1'b0;
      err_blank_par <= 1'b0;
    end else begin
      err_odd_len   <= err_odd_len   || (flush && !split_clr);
      err_blank_par <= err_blank_par || (blank_set && !split_clr);
      out_oe        <= !pwr_down;
      if (pwr_down) begin
        out_valid <= 1'b0;
        out_b_en  <= 1'b0;
        out_pix_a <= '0;
        out_pix_b <= '0;
        out_de    <= 1'b0;
        out_hs    <= 1'b0;
        out_vs    <= 1'b0;
      end else begin
        out_de <= f_de;
        out_hs <= f_hs;
        out_vs <= f_vs;
        case (mode)
          MODE_SPLIT: begin
            out_valid <= p_valid;
            out_b_en  <= 1'b1;
            out_pix_a <= p_valid ? p_a : '0;
            out_pix_b <= p_valid ? p_b : '0;
          end
          MODE_DUAL: begin
            out_valid <= f_de;
            out_b_en  <= 1'b1;
            out_pix_a <= f_de ? f_pa : '0;
            out_pix_b <= f_de ? f_pb : '0;
          end
          default: begin
            out_valid <= f_de;
            out_b_en  <= 1'b0;
            out_pix_a <= f_de ? f_pa : '0;
            out_pix_b <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pps_chk.sv
module pps_chk #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             pwr_down,
  input logic             out_oe,
  input logic             out_valid,
  input logic             out_b_en,
  input logic [PIX_W-1:0] out_pix_a,
  input logic [PIX_W-1:0] out_pix_b,
  input logic             err_odd_len,
  input logic             err_blank_par
);
  AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> (!out_oe && !out_valid && out_pix_a == '0 && out_pix_b == '0)); // R8

  AST_SINGLE_B_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 || mode == 2'b11) |=> (!out_b_en && out_pix_b == '0)); // R6

  AST_DUAL_B_ON: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && !pwr_down) |=> out_b_en); // R7

  AST_SPLIT_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode == 2'b10) |=> !out_valid); // R2

  AST_ODD_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_odd_len |=> err_odd_len); // R4

  AST_FLUSH_B_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(err_odd_len) |-> (out_valid && out_pix_b == '0)); // R4

  AST_BLANK_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_blank_par |=> err_blank_par); // R5
endmodule

bind pix_pair_split pps_chk #(.PIX_W(PIX_W)) i_chk (
  .clk(clk), .rst(rst), .mode(mode), .pwr_down(pwr_down),
  .out_oe(out_oe), .out_valid(out_valid), .out_b_en(out_b_en),
  .out_pix_a(out_pix_a), .out_pix_b(out_pix_b),
  .err_odd_len(err_odd_len), .err_blank_par(err_blank_par)
);

// File: tb/test_pix_pair_split.sv
`timescale 1ns/1ps
module test_pix_pair_split;
  localparam int PW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'b00;
  logic          pwr_down = 1'b0;
  logic          edge_sel = 1'b0;
  logic          in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [PW-1:0] in_pix_a = '0, in_pix_b = '0;
  logic          in_ready, out_oe, out_valid, out_b_en;
  logic [PW-1:0] out_pix_a, out_pix_b;
  logic          out_de, out_hs, out_vs, err_odd_len, err_blank_par;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pix_pair_split i_pix_pair_split (
    .clk(clk), .rst(rst), .mode(mode), .pwr_down(pwr_down), .edge_sel(edge_sel),
    .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
    .in_pix_a(in_pix_a), .in_pix_b(in_pix_b), .in_ready(in_ready),
    .out_oe(out_oe), .out_valid(out_valid), .out_b_en(out_b_en),
    .out_pix_a(out_pix_a), .out_pix_b(out_pix_b),
    .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
    .err_odd_len(err_odd_len), .err_blank_par(err_blank_par)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Inputs change after a falling edge; the step ends at the next falling edge.
  // An output sampled after step k reflects the input of step k-1 (edge_sel low).
  task automatic step(input logic de, input logic hs, input logic [PW-1:0] a,
                      input logic [PW-1:0] b = '0);
    in_de = de; in_hs = hs; in_vs = 1'b0; in_pix_a = a; in_pix_b = b;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0);
  endtask

  task automatic do_reset(input logic [1:0] m);
    mode = m; pwr_down = 1'b0; edge_sel = 1'b0; rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    mode = 2'b10; rst = 1'b1;
    idle(2);
    chk("R1 out_oe in reset", out_oe, 0);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 lanes in reset", {out_pix_a, out_pix_b}, 0);
    chk("R1 errors in reset", {err_odd_len, err_blank_par}, 0);
    rst = 1'b0;
    idle(1);
    chk("R1 out_oe after release", out_oe, 1);
  endtask

  task automatic t_split;
    do_reset(2'b10);
    idle(2);
    step(1'b1, 1'b0, 24'h111111);
    step(1'b1, 1'b1, 24'h222222);
    step(1'b1, 1'b0, 24'h333333);
    chk("R2 first pair valid", out_valid, 1);
    chk("R2 odd on lane A", out_pix_a, 24'h111111);
    chk("R2 even on lane B", out_pix_b, 24'h222222);
    chk("R3 hs of even pixel", out_hs, 1);
    chk("R3 de on pair", out_de, 1);
    step(1'b1, 1'b0, 24'h444444);
    chk("R2 no strobe on odd", out_valid, 0);
    chk("R2 lanes zero idle", {out_pix_a, out_pix_b}, 0);
    step(1'b0, 1'b0, '0);
    chk("R2 second pair", {out_valid, out_pix_a, out_pix_b}, {1'b1, 24'h333333, 24'h444444});
    chk("R2 lane B enabled", out_b_en, 1);
    step(1'b0, 1'b0, '0);
    chk("R2 no strobe after region", out_valid, 0);
    chk("R4 no odd error on even run", err_odd_len, 0);
  endtask

  task automatic t_odd;
    do_reset(2'b10);
    step(1'b1, 1'b0, 24'hA00001);
    step(1'b1, 1'b0, 24'hA00002);
    step(1'b1, 1'b0, 24'hA00003);
    chk("R2 pair before flush", {out_valid, out_pix_a, out_pix_b}, {1'b1, 24'hA00001, 24'hA00002});
    step(1'b0, 1'b0, '0);
    chk("R4 no early flush", out_valid, 0);
    step(1'b0, 1'b0, '0);
    chk("R4 flush strobe", out_valid, 1);
    chk("R4 flush lane A", out_pix_a, 24'hA00003);
    chk("R4 flush lane B zero", out_pix_b, 0);
    chk("R4 odd error set", err_odd_len, 1);
    idle(3);
    chk("R4 odd error sticky", err_odd_len, 1);
    chk("R4 no extra strobe", out_valid, 0);
  endtask

  task automatic t_blank;
    do_reset(2'b10);
    step(1'b1, 1'b0, 24'h0000A1);
    step(1'b1, 1'b0, 24'h0000A2);
    idle(2);
    step(1'b1, 1'b0, 24'h0000C1);
    step(1'b1, 1'b0, 24'h0000C2);
    chk("R5 even blank no error", err_blank_par, 0);
    idle(1);
    chk("R5 pair after even blank", {out_valid, out_pix_a, out_pix_b}, {1'b1, 24'h0000C1, 24'h0000C2});
    idle(2);
    step(1'b1, 1'b0, 24'h0000B1);
    chk("R5 no error before region", err_blank_par, 0);
    step(1'b1, 1'b0, 24'h0000B2);
    chk("R5 odd blank error", err_blank_par, 1);
    idle(1);
    chk("R5 rephased pair", {out_valid, out_pix_a, out_pix_b}, {1'b1, 24'h0000B1, 24'h0000B2});
    idle(2);
    chk("R5 error sticky", err_blank_par, 1);
  endtask

  task automatic t_single;
    do_reset(2'b00);
    in_vs = 1'b1;
    in_de = 1'b1; in_hs = 1'b1; in_pix_a = 24'h5A5A01; in_pix_b = 24'hFFFFFF;
    @(negedge clk);
    step(1'b1, 1'b0, 24'h5A5A02, 24'hFFFFFF);
    chk("R6 single lane A", {out_valid, out_pix_a}, {1'b1, 24'h5A5A01});
    chk("R6 single lane B zero", out_pix_b, 0);
    chk("R6 single b_en low", out_b_en, 0);
    chk("R3 single syncs", {out_de, out_hs, out_vs}, 3'b111);
    step(1'b0, 1'b0, '0);
    chk("R6 next pixel", {out_valid, out_pix_a, out_pix_b}, {1'b1, 24'h5A5A02, 24'h0});
    step(1'b0, 1'b0, '0);
    chk("R6 idle", {out_valid, out_pix_a}, 0);
    mode = 2'b11;
    step(1'b1, 1'b0, 24'h777777, 24'h123456);
    step(1'b0, 1'b0, '0);
    chk("R6 code 11 single", {out_valid, out_b_en, out_pix_a, out_pix_b}, {2'b10, 24'h777777, 24'h0});
  endtask

  task automatic t_dual;
    do_reset(2'b01);
    step(1'b1, 1'b0, 24'hD0D0A0, 24'hD0D0B0);
    step(1'b1, 1'b0, 24'hD1D1A1, 24'hD1D1B1);
    chk("R7 dual both lanes", {out_valid, out_pix_a, out_pix_b}, {1'b1, 24'hD0D0A0, 24'hD0D0B0});
    chk("R7 dual b_en", out_b_en, 1);
    step(1'b0, 1'b0, '0);
    chk("R7 dual consecutive", {out_valid, out_pix_a, out_pix_b}, {1'b1, 24'hD1D1A1, 24'hD1D1B1});
  endtask

  task automatic t_pd;
    do_reset(2'b10);
    step(1'b1, 1'b0, 24'hE00001);
    pwr_down = 1'b1;
    step(1'b1, 1'b0, 24'hE00002);
    chk("R8 ready low", in_ready, 0);
    chk("R8 oe low", out_oe, 0);
    chk("R8 outputs zero", {out_valid, out_b_en, out_pix_a, out_pix_b, out_de}, 0);
    step(1'b1, 1'b0, 24'hE00003);
    chk("R8 still quiet", {out_oe, out_valid}, 0);
    pwr_down = 1'b0;
    step(1'b1, 1'b0, 24'hE00004);
    chk("R8 ready back", in_ready, 1);
    chk("R8 oe back", out_oe, 1);
    step(1'b1, 1'b0, 24'hE00005);
    chk("R8 no stale flush", out_valid, 0);
    step(1'b0, 1'b0, '0);
    chk("R8 fresh pair", {out_valid, out_pix_a, out_pix_b}, {1'b1, 24'hE00004, 24'hE00005});
    chk("R8 no errors", {err_odd_len, err_blank_par}, 0);
  endtask

  task automatic t_edge;
    do_reset(2'b00);
    edge_sel = 1'b1;
    step(1'b1, 1'b0, 24'hC0FFEE);
    step(1'b0, 1'b0, '0);
    chk("R9 not yet out", out_valid, 0);
    step(1'b0, 1'b0, '0);
    chk("R9 late output", {out_valid, out_pix_a}, {1'b1, 24'hC0FFEE});
    step(1'b0, 1'b0, '0);
    chk("R9 gone", out_valid, 0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_split();
    t_odd();
    t_blank();
    t_single();
    t_dual();
    t_pd();
    t_edge();
    finish_run();
  end
endmodule